// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Generator and Checker

This block handles the 4-bit cyclic check carried in an E1 (2.048 Mbit/s) framed stream. It takes one bit per clock while a valid strobe is high. It runs its own bit and frame counters, and an external sync pulse aligns those counters to the multiframe. A 256-bit frame holds 32 time slots of 8 bits each. Eight frames make one 2048-bit submultiframe, and two submultiframes make one multiframe.

The block reserves one check-bit slot in each even frame of a submultiframe. For every submultiframe it computes the remainder with those slots read as zero. It then writes that remainder into the check slots of the following submultiframe on the serial output. All other bits pass through unchanged. The block also captures the check bits that arrive on the input. When a submultiframe ends, it compares them against the remainder of the submultiframe before it and raises a one-clock flag if they differ. The generated stream and the check flag are both available all the time, so the block serves a transmit path and a receive path without a mode input.

Top module: `e1crc4_gen`

## Requirements
- R1: While reset is held and on the first clock after it, `dataOutValid` and `crcErr` are 0.
- R2: Every input bit taken with `bitValid` high comes out on `dataOut` one clock later with `dataOutValid` high. A bit that is not in a check slot is copied unchanged.
- R3: A clock with `bitValid` low moves no counter, changes no state, and gives `dataOutValid` 0 and `crcErr` 0 one clock later. A `mfSync` pulse on such a clock is ignored.
- R4: The check slots are bit 0 of frames 0, 2, 4 and 6 of each submultiframe. On the output they carry the remainder of the previous complete submultiframe: its most significant bit goes into frame 0, and the lower bits follow in descending order into frames 2, 4 and 6.
- R5: The remainder is the 4-bit residue of the submultiframe, with its check slots forced to 0 and four zero bits appended, divided modulo 2 by x^4 + x + 1. The register is cleared at the start of each submultiframe, so the values that arrive in the input check slots never affect it.
- R6: Until the first submultiframe after reset has completed, the check slots are output as 0.
- R7: A bit taken with both `mfSync` and `bitValid` high is treated as bit 0 of frame 0. This restarts the counters and the running remainder. A submultiframe that was cut short by the restart leaves the stored remainder unchanged.
- R8: One clock after the last bit of a submultiframe, `crcErr` pulses high for one clock if the four check bits received in that submultiframe differ from the remainder of the previous complete submultiframe. It never pulses for the first submultiframe after reset.
- R9: A submultiframe whose payload is all zeros gives a remainder of 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | Qualifies `bitIn` on this clock |
| mfSync | input | 1 | Marks the current valid bit as the first bit of a multiframe |
| dataOut | output | 1 | Serial stream with the check slots filled |
| dataOutValid | output | 1 | Qualifies `dataOut` |
| crcErr | output | 1 | One-clock flag: received check bits did not match |

## Verification
The checker assumes that `mfSync` is only meaningful together with `bitValid`. It keeps its own position count, which restarts on every sync, and uses it to predict which output bits are plain copies and where a mismatch flag may appear. The stimulus never places two submultiframe ends closer together than 2048 valid bits, so a single-clock pulse check is sound. It inserts idle clocks at random points and raises sync only on bits that are intended to begin a multiframe, including one restart partway through a submultiframe.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;
  localparam int FRAME_BITS = 256;        // bits per frame
  localparam int SMF_FRAMES = 8;          // frames per submultiframe
  localparam int CRC_W      = 4;          // check width
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;  // x^4 + x + 1, top term implied
  localparam int CIDX_W     = $clog2(CRC_W);

  // strobes from the position control to the datapath
  typedef struct packed {
    logic              take;      // bit accepted this clock
    logic              blkStart;  // first bit of a submultiframe
    logic              blkEnd;    // last bit of a submultiframe
    logic              cSlot;     // bit is a check slot
    logic [CIDX_W-1:0] cIdx;      // which check slot, 0 = most significant
  } crcCtl_t;
endpackage

// File: rtl/e1crc_ctrl.sv
module e1crc_ctrl
  import e1crc_pkg::*;
#(
  parameter int FrameBits = FRAME_BITS,
  parameter int SmfFrames = SMF_FRAMES
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitValid,
  input  logic     mfSync,
  output crcCtl_t  ctl
);
  localparam int BIT_W = $clog2(FrameBits);
  localparam int FRM_W = $clog2(SmfFrames);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FrameBits - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(SmfFrames - 1);

  logic [BIT_W-1:0] bitCnt, bitPos;
  logic [FRM_W-1:0] frmCnt, frmPos;

  // a sync pulse places the current bit at frame 0, bit 0
  always_comb begin
    bitPos = mfSync ? '0 : bitCnt;
    frmPos = mfSync ? '0 : frmCnt;
    ctl.take     = bitValid;
    ctl.blkStart = bitValid && (bitPos == '0) && (frmPos == '0);
    ctl.blkEnd   = bitValid && (bitPos == BIT_LAST) && (frmPos == FRM_LAST);
    ctl.cSlot    = bitValid && (bitPos == '0) && !frmPos[0];
    ctl.cIdx     = CIDX_W'(frmPos >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      frmCnt <= '0;
    end else if (bitValid) begin
      if (bitPos == BIT_LAST) begin
        bitCnt <= '0;
        frmCnt <= (frmPos == FRM_LAST) ? '0 : frmPos + 1'b1;
      end else begin
        bitCnt <= bitPos + 1'b1;
        frmCnt <= frmPos;
      end
    end
  end
endmodule

// File: rtl/e1crc_dp.sv
module e1crc_dp
  import e1crc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitIn,
  input  crcCtl_t ctl,
  output logic    dataOut,
  output logic    dataOutValid,
  output logic    crcErr
);
  logic [CRC_W-1:0] crcReg, crcBase, crcNext, heldRem, rxC, rxCNext;
  logic             haveRem, din, fb;
  int               slotBit;

  always_comb begin
    slotBit = CRC_W - 1 - int'(ctl.cIdx);
    din     = ctl.cSlot ? 1'b0 : bitIn;          // check slots read as zero
    crcBase = ctl.blkStart ? '0 : crcReg;        // fresh register per block
    fb      = crcBase[CRC_W-1] ^ din;
    crcNext = {crcBase[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    rxCNext = rxC;
    if (ctl.cSlot) rxCNext[slotBit] = bitIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg       <= '0;
      heldRem      <= '0;
      rxC          <= '0;
      haveRem      <= 1'b0;
      dataOut      <= 1'b0;
      dataOutValid <= 1'b0;
      crcErr       <= 1'b0;
    end else begin
      dataOutValid <= ctl.take;
      crcErr       <= 1'b0;
      if (ctl.take) begin
        crcReg  <= crcNext;
        rxC     <= rxCNext;
        dataOut <= ctl.cSlot ? heldRem[slotBit] : bitIn;
        if (ctl.blkEnd) begin
          heldRem <= crcNext;
          haveRem <= 1'b1;
          crcErr  <= haveRem && (rxCNext != heldRem);
        end
      end
    end
  end
endmodule

// File: rtl/e1crc4_gen.sv
module e1crc4_gen
  import e1crc_pkg::*;
#(
  parameter int FrameBits = FRAME_BITS,
  parameter int SmfFrames = SMF_FRAMES
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic bitValid,
  input  logic mfSync,
  output logic dataOut,
  output logic dataOutValid,
  output logic crcErr
);
  crcCtl_t ctl;

  e1crc_ctrl #(.FrameBits(FrameBits), .SmfFrames(SmfFrames)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .mfSync(mfSync), .ctl(ctl)
  );

  e1crc_dp u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .ctl(ctl),
    .dataOut(dataOut), .dataOutValid(dataOutValid), .crcErr(crcErr)
  );
endmodule

// File: rtl/e1crc4_chk.sv
module e1crc4_chk #(
  parameter int FrameBits = 256,
  parameter int SmfFrames = 8
) (
  input logic clk,
  input logic rstN,
  input logic bitIn,
  input logic bitValid,
  input logic mfSync,
  input logic dataOut,
  input logic dataOutValid,
  input logic crcErr
);
  localparam int BLK   = FrameBits * SmfFrames;
  localparam int POS_W = $clog2(BLK);
  localparam int BIT_W = $clog2(FrameBits);

  logic [POS_W-1:0] posCnt, curPos;
  logic             payloadBit, lastBit;

  always_comb begin
    curPos     = mfSync ? '0 : posCnt;
    payloadBit = bitValid && !((curPos[BIT_W-1:0] == '0) && !curPos[BIT_W]);
    lastBit    = bitValid && (curPos == POS_W'(BLK - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) posCnt <= '0;
    else if (bitValid) posCnt <= (curPos == POS_W'(BLK - 1)) ? '0 : curPos + 1'b1;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> dataOutValid);
  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> (!dataOutValid && !crcErr));
  a_r2_payload_copied: assert property (@(posedge clk) disable iff (!rstN)
    payloadBit |=> (dataOut == $past(bitIn)));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |=> !crcErr);
  a_r8_err_at_block_end: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> $past(lastBit));
endmodule

bind e1crc4_gen e1crc4_chk #(.FrameBits(FrameBits), .SmfFrames(SmfFrames)) u_chk (
  .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .mfSync(mfSync),
  .dataOut(dataOut), .dataOutValid(dataOutValid), .crcErr(crcErr)
);

// File: tb/test_e1crc4_gen.sv
module test_e1crc4_gen;
  localparam int FB = 256;
  localparam int NF = 8;
  localparam int SB = FB * NF;

  logic clk = 1'b0, rstN = 1'b0, bitIn = 1'b0, bitValid = 1'b0, mfSync = 1'b0;
  logic dataOut, dataOutValid, crcErr;
  int   nChk = 0, nBad = 0;
  bit   done = 1'b0;
  logic payload [SB];

  always #10 clk = ~clk;  // 50 MHz

  e1crc4_gen i_e1crc4_gen (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .mfSync(mfSync),
    .dataOut(dataOut), .dataOutValid(dataOutValid), .crcErr(crcErr)
  );

  task automatic check(string req, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isC(int p);
    return ((p % FB) == 0) && (((p / FB) % 2) == 0);
  endfunction

  // long division of the augmented block by 10011
  function automatic logic [3:0] remOf();
    logic m [SB+4];
    for (int i = 0; i < SB; i++) m[i] = payload[i];
    for (int i = SB; i < SB + 4; i++) m[i] = 1'b0;
    for (int i = 0; i < SB; i++)
      if (m[i]) begin
        m[i] = 1'b0; m[i+3] = ~m[i+3]; m[i+4] = ~m[i+4];
      end
    return {m[SB], m[SB+1], m[SB+2], m[SB+3]};
  endfunction

  task automatic idleCheck(string req);
    @(posedge clk); #1;
    check({req, " idle valid"}, dataOutValid, 1'b0);
    check({req, " idle err"}, crcErr, 1'b0);
  endtask

  task automatic sendBit(logic b, logic s, logic expOut, logic expErr, string req);
    bitIn = b; bitValid = 1'b1; mfSync = s;
    @(posedge clk); #1;
    bitValid = 1'b0; mfSync = 1'b0;
    check("R2 valid", dataOutValid, 1'b1);
    check(req, dataOut, expOut);
    check("R8 err flag", crcErr, expErr);
    if (($urandom % 23) == 0) begin
      mfSync = ($urandom % 2) == 1;    // R3: sync without valid is ignored
      idleCheck("R3");
      mfSync = 1'b0;
    end
  endtask

  // one submultiframe (or a prefix of one)
  task automatic runSmf(bit sync, bit zeroPay, int nBits, bit havePrev,
                        logic [3:0] prevRem, bit corrupt, output logic [3:0] rem);
    for (int p = 0; p < SB; p++)
      payload[p] = (zeroPay || isC(p)) ? 1'b0 : 1'($urandom);
    rem = remOf();
    for (int p = 0; p < nBits; p++) begin
      if (isC(p)) begin
        int  k = p / (2 * FB);
        logic exp = havePrev ? prevRem[3-k] : 1'b0;
        logic rx  = havePrev ? (prevRem[3-k] ^ (corrupt && k == 0)) : 1'b1;
        sendBit(rx, sync && p == 0, exp, 1'b0, havePrev ? "R4 check slot" : "R6 check slot");
      end else begin
        sendBit(payload[p], sync && p == 0, payload[p],
                (p == SB - 1) && havePrev && corrupt, "R2 payload copy");
      end
    end
  endtask

  initial begin
    logic [3:0] r0, r1, r2, r3, r4, r5, r6;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", dataOutValid, 1'b0);
    check("R1 err in reset", crcErr, 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after reset", dataOutValid, 1'b0);
    check("R1 err after reset", crcErr, 1'b0);
    mfSync = 1'b1;
    idleCheck("R3 sync alone");
    mfSync = 1'b0;

    runSmf(1, 1, SB, 0, 4'h0, 0, r0);          // R9 zero payload, R6, R5 C ignored
    check("R9 model zero remainder", r0[3] | r0[2] | r0[1] | r0[0], 1'b0);
    runSmf(0, 0, SB, 1, r0, 0, r1);            // R4 shows 0000 from zero block (R9)
    runSmf(1, 0, SB, 1, r1, 0, r2);
    runSmf(0, 0, SB, 1, r2, 1, r3);            // R8 mismatch expected
    runSmf(1, 0, 700, 1, r3, 0, r4);           // cut short by the next sync
    runSmf(1, 0, SB, 1, r3, 0, r5);            // R7 restart, stored remainder kept
    runSmf(0, 0, SB, 1, r5, 1, r6);            // R5 R8 after restart
    runSmf(0, 0, 2 * FB + 1, 1, r6, 0, r4);
    idleCheck("R3 tail");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule